// File: doc/BRIEF.md
# Multi-Unit Synchronizing Period Oscillator

This block is a counter-based oscillator that sets the switching period for a phase-shifting bridge PWM stage. A counter runs up to a programmed period length. When the count expires, the block produces a one-cycle period tick for the PWM generator. At the same moment it drives a short pulse onto a shared synchronization line.

The line is bidirectional. Several units may be joined on it, or an external clock may drive it. Each unit watches the line through a two-flop synchronizer and an edge detector. If a rising edge arrives before the local count expires, the unit restarts its period and drives nothing in that period. As a result, a group of joined units follows whichever unit has the shortest period. An external clock takes over only when it is faster than the local setting. If the line is cut, each unit keeps running at its own rate.

The pad driver is outside this block. Pad drive and the shaping of the analog pulse width are not modelled. The top presents `sync_out` and a drive enable `sync_oe`, and it expects the resolved line level on `sync_in`. There is no data stream, so every pin is a plain control or status signal with no handshake.

Top module: `sync_osc`

## Requirements
- R1: While `rst_n` is low, `tick_o`, `sync_out` and `sync_oe` are low and the period count is zero. The first local tick comes in the cycle that follows the effective-period-th rising clock edge after reset is released.
- R2: With no rising edge on `sync_in`, `tick_o` pulses for one cycle once every effective period. The effective period is `period_i` clock cycles.
- R3: On a local expiry, `sync_out` and `sync_oe` rise in the same cycle as `tick_o` and stay high for exactly PULSE_CLKS cycles (default 2).
- R4: Take the first clock edge that samples `sync_in` high after it was low. If the period count is at least BLANK = PULSE_CLKS + SYNC_STAGES + 1 (default 5), `tick_o` is high in the third cycle after that edge and the count restarts from zero. `sync_out` and `sync_oe` stay low for a period started this way.
- R5: A rising edge that the edge detector sees while the count is below BLANK is ignored. This includes the unit's own pulse echoed back on `sync_in`.
- R6: A `period_i` value below MIN_PERIOD = BLANK + 1 (default 6) is treated as MIN_PERIOD, so two ticks are always at least MIN_PERIOD cycles apart.
- R7: If a local expiry and an accepted sync edge fall in the same cycle, the expiry wins: one tick is produced and the sync pulse is driven.
- R8: Detection is edge-triggered. A line held high causes at most one restart, and the unit then keeps running at its own period. When the line goes quiet, local operation carries on with no loss of ticks.
- R9: `period_i` is compared live. If the count is already at or beyond the new effective period minus one, the count expires at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_i | input | CNT_W | Local period length in clock cycles |
| sync_in | input | 1 | Resolved level of the shared sync line (asynchronous) |
| sync_out | output | 1 | Sync pulse level to drive onto the line |
| sync_oe | output | 1 | Drive enable for the sync line pad |
| tick_o | output | 1 | One-cycle period start strobe to the PWM generator |

## Verification
The bench loops `sync_out` back onto `sync_in`, so the unit always sees its own pulse. A design without echo blanking would therefore restart itself a few cycles into every period. External pulses are placed just below and exactly at the BLANK count. A design that blanked for the wrong number of cycles would accept the early pulse or drop the on-time one.

A faster external clock must take over and silence `sync_out`, while a slower one must not stop the local pulses. A design that is level-sensitive would keep restarting while the line is held high. Further cases cover an edge aligned with the expiry cycle, a period below the minimum, and a period that shrinks mid-count. Each of these exposes a wrong priority order, a missing clamp, or an equality-only compare that would run past the new period.

// File: rtl/sync_osc_pkg.sv
package sync_osc_pkg;

  // Clamp a requested period to the shortest one the blanking window allows.
  function automatic logic [31:0] clamp_period(input logic [31:0] req,
                                               input logic [31:0] floor_v);
    return (req < floor_v) ? floor_v : req;
  endfunction

endpackage

// File: rtl/sync_osc_sync.sv
module sync_osc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic rise_o
);
  // sh[0..STAGES-1] form the synchronizer; sh[STAGES] holds the previous value
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh[0] <= 1'b0;
    else        sh[0] <= d_i;
  end

  for (genvar i = 1; i <= STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh[i] <= 1'b0;
      else        sh[i] <= sh[i-1];
    end
  end

  assign rise_o = sh[STAGES-1] & ~sh[STAGES];

endmodule

// File: rtl/sync_osc_period.sv
module sync_osc_period
  import sync_osc_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int BLANK   = 5,
  parameter int MIN_PER = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_i,
  input  logic             rise_i,
  output logic             expire_o,
  output logic             tick_o
);
  localparam logic [CNT_W-1:0] BLANK_C = CNT_W'(BLANK);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] eff_per;
  logic             accept;

  assign eff_per  = CNT_W'(clamp_period(32'(period_i), 32'(MIN_PER)));
  assign expire_o = (cnt_q >= eff_per - CNT_W'(1));
  assign accept   = rise_i && (cnt_q >= BLANK_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (expire_o || accept) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + CNT_W'(1);
      tick_o <= 1'b0;
    end
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o); // R6
  AST_BLANK_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i && (cnt_q < BLANK_C) && !expire_o) |=> !tick_o); // R5
  AST_EDGE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i && (cnt_q >= BLANK_C)) |=> (tick_o && cnt_q == '0)); // R4

endmodule

// File: rtl/sync_osc_pulse.sv
module sync_osc_pulse #(
  parameter int PULSE_CLKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic pulse_o
);
  localparam int PW_W = $clog2(PULSE_CLKS + 1);
  localparam logic [PW_W-1:0] LEN = PW_W'(PULSE_CLKS);

  logic [PW_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (start_i)        left_q <= LEN;
    else if (left_q != '0)   left_q <= left_q - PW_W'(1);
  end

  assign pulse_o = (left_q != '0);

endmodule

// File: rtl/sync_osc.sv
module sync_osc #(
  parameter int CNT_W       = 16,
  parameter int PULSE_CLKS  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_i,
  input  logic             sync_in,
  output logic             sync_out,
  output logic             sync_oe,
  output logic             tick_o
);
  // own echo reaches the detector at count SYNC_STAGES; window covers pulse too
  localparam int BLANK   = PULSE_CLKS + SYNC_STAGES + 1;
  localparam int MIN_PER = BLANK + 1;

  logic rise;
  logic expire;
  logic pulse;

  sync_osc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_i    (sync_in),
    .rise_o (rise)
  );

  sync_osc_period #(.CNT_W(CNT_W), .BLANK(BLANK), .MIN_PER(MIN_PER)) u_period (
    .clk      (clk),
    .rst_n    (rst_n),
    .period_i (period_i),
    .rise_i   (rise),
    .expire_o (expire),
    .tick_o   (tick_o)
  );

  sync_osc_pulse #(.PULSE_CLKS(PULSE_CLKS)) u_pulse (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (expire),
    .pulse_o (pulse)
  );

  assign sync_out = pulse;
  assign sync_oe  = pulse;

  // run length of the drive enable, for the width check
  logic [CNT_W-1:0] hi_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hi_run <= '0;
    else if (!sync_oe) hi_run <= '0;
    else               hi_run <= hi_run + CNT_W'(1);
  end

  AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_oe) |-> (hi_run == CNT_W'(PULSE_CLKS))); // R3
  AST_PULSE_WITH_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_oe) |-> tick_o); // R3
  AST_SYNCED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && !sync_oe) |-> $past(rise)); // R4

endmodule

// File: tb/sync_osc_tb.sv
`timescale 1ns/1ps
module sync_osc_tb_top;
  localparam int CNT_W = 16;
  localparam int PULSE = 2;
  localparam int STG   = 2;
  localparam int BLANK = PULSE + STG + 1;
  localparam int MINP  = BLANK + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CNT_W-1:0] period = 16'd20;
  logic ext = 1'b0;
  logic sync_out, sync_oe, tick_o, sync_line;

  always #2.5 clk = ~clk;

  assign sync_line = ext | sync_out;

  sync_osc #(.CNT_W(CNT_W), .PULSE_CLKS(PULSE), .SYNC_STAGES(STG)) dut_i (
    .clk(clk), .rst_n(rst_n), .period_i(period), .sync_in(sync_line),
    .sync_out(sync_out), .sync_oe(sync_oe), .tick_o(tick_o));

  int n_chk = 0, n_fail = 0;
  string tag = "R1";

  // behavioural reference state
  int m_cnt = 0, m_pc = 0;
  bit m_tick = 0, m_out = 0;
  bit hist[$] = '{0, 0, 0};

  int cycle_no = 0, last_tick = 0, last_iv = 0, n_pulses = 0, so_run = 0;
  bit prev_so = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp_v, cycle_no);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic model_advance(input bit line, input int p);
    int eff;
    bit edge_seen, exp_now;
    eff = (p < MINP) ? MINP : p;
    edge_seen = hist[1] && !hist[2];
    exp_now = (m_cnt >= eff - 1);
    if (exp_now) begin
      m_cnt = 0; m_tick = 1; m_pc = PULSE;
    end else begin
      if (m_pc > 0) m_pc--;
      if (edge_seen && m_cnt >= BLANK) begin m_cnt = 0; m_tick = 1; end
      else begin m_cnt++; m_tick = 0; end
    end
    m_out = (m_pc > 0);
    hist.push_front(line);
    void'(hist.pop_back());
  endtask

  task automatic cyc(input bit e, input int p);
    bit line;
    @(negedge clk);
    cycle_no++;
    chk(tick_o === m_tick, tag, int'(tick_o), int'(m_tick));
    chk(sync_out === m_out, tag, int'(sync_out), int'(m_out));
    chk(sync_oe === m_out, tag, int'(sync_oe), int'(m_out));
    if (tick_o) begin last_iv = cycle_no - last_tick; last_tick = cycle_no; end
    if (sync_out && !prev_so) n_pulses++;
    if (sync_out) so_run++;
    else if (prev_so) begin
      chk(so_run == PULSE, "R3", so_run, PULSE);
      so_run = 0;
    end
    prev_so = sync_out;
    line = m_out | e;
    ext = e;
    period = CNT_W'(p);
    model_advance(line, p);
  endtask

  task automatic run(input int n, input int p);
    for (int i = 0; i < n; i++) cyc(1'b0, p);
  endtask

  task automatic wait_cnt(input int c, input int p);
    while (m_cnt != c) cyc(1'b0, p);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int rel, ps;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(tick_o === 1'b0, "R1", int'(tick_o), 0);
    chk(sync_out === 1'b0 && sync_oe === 1'b0, "R1", int'(sync_out), 0);
    @(negedge clk);
    rst_n = 1'b1;
    rel = cycle_no;
    model_advance(1'b0, 20);
    while (!tick_o) cyc(1'b0, 20);
    chk(last_tick - rel == 20, "R1", last_tick - rel, 20);

    // R2/R3/R5: free run with own echo looped back
    tag = "R2";
    run(70, 20);
    chk(last_iv == 20, "R2", last_iv, 20);
    chk(n_pulses >= 4, "R3", n_pulses, 4);

    // R5: external edge lands below BLANK -> ignored
    tag = "R5";
    wait_cnt(2, 20);
    ps = last_tick;
    cyc(1'b1, 20);
    while (last_tick == ps) cyc(1'b0, 20);
    chk(last_iv == 20, "R5", last_iv, 20);

    // R4: external edge at exactly BLANK -> restart, no drive
    tag = "R4";
    wait_cnt(3, 20);
    ps = n_pulses;
    cyc(1'b1, 20);
    cyc(1'b0, 20); cyc(1'b0, 20); cyc(1'b0, 20);
    chk(tick_o === 1'b1, "R4", int'(tick_o), 1);
    chk(last_iv == 6, "R4", last_iv, 6);
    chk(n_pulses == ps, "R4", n_pulses, ps);

    // R4: faster external clock (14) takes over, local drive silenced
    for (int k = 0; k < 6; k++) begin
      cyc(1'b1, 20); cyc(1'b1, 20);
      for (int j = 0; j < 12; j++) cyc(1'b0, 20);
    end
    ps = n_pulses;
    for (int k = 0; k < 3; k++) begin
      cyc(1'b1, 20); cyc(1'b1, 20);
      for (int j = 0; j < 12; j++) cyc(1'b0, 20);
    end
    chk(last_iv == 14, "R4", last_iv, 14);
    chk(n_pulses == ps, "R4", n_pulses, ps);

    // R8: link broken -> local operation resumes
    tag = "R8";
    ps = n_pulses;
    run(60, 20);
    chk(last_iv == 20, "R8", last_iv, 20);
    chk(n_pulses - ps >= 2, "R8", n_pulses - ps, 2);

    // R2: slower external clock (30) does not stop local pulses
    tag = "R2";
    ps = n_pulses;
    for (int k = 0; k < 4; k++) begin
      cyc(1'b1, 20);
      for (int j = 0; j < 29; j++) cyc(1'b0, 20);
    end
    chk(n_pulses - ps >= 1, "R2", n_pulses - ps, 1);

    // R8: line held high -> one restart, then free run
    tag = "R8";
    ps = n_pulses;
    for (int k = 0; k < 70; k++) cyc(1'b1, 20);
    chk(last_iv == 20, "R8", last_iv, 20);
    chk(n_pulses - ps >= 2, "R8", n_pulses - ps, 2);
    run(30, 20);

    // R7: accepted edge coincides with expiry -> expiry wins, pulse driven
    tag = "R7";
    wait_cnt(17, 20);
    ps = n_pulses;
    cyc(1'b1, 20);
    cyc(1'b0, 20); cyc(1'b0, 20); cyc(1'b0, 20);
    chk(tick_o === 1'b1 && sync_out === 1'b1, "R7", int'(sync_out), 1);
    chk(n_pulses == ps + 1, "R7", n_pulses, ps + 1);
    run(25, 20);

    // R9: period shrinks below current count -> expire on next edge
    tag = "R9";
    wait_cnt(12, 20);
    cyc(1'b0, 8);
    cyc(1'b0, 8);
    chk(tick_o === 1'b1, "R9", int'(tick_o), 1);
    run(20, 8);
    chk(last_iv == 8, "R9", last_iv, 8);

    // R6: period below minimum is clamped
    tag = "R6";
    run(30, 2);
    chk(last_iv == MINP, "R6", last_iv, MINP);
    run(20, 0);
    chk(last_iv == MINP, "R6", last_iv, MINP);

    report();
  end

endmodule